// File: doc/BRIEF.md
# Triggered 8-bit synchronous serial port

A shift unit that sits on a narrow 4-bit register bus. Software loads an 8-bit transfer word through two nibble-wide data registers, one for the low nibble and one for the high nibble. It then sets a start bit in a control register. The port sends the word on `sdo`, least significant bit first, and shifts the bits arriving on `sdi` into the same word. After the last bit, software reads the received byte back through the same two nibble registers.

The shift clock has two sources, chosen by `ext_mode`:
- **Internal:** the port drives `sclk_out` itself. The clock toggles once per `tick_en` strobe.
- **External:** the port follows a partner's clock on `sclk_in`. That clock passes through a two-flop synchronizer and an edge detector in the system clock domain.

The output bit changes on the falling shift-clock edge. The input bit is taken on the rising edge.

A start is accepted only when the engine has been armed. Any read or write of a data register while the port is idle arms it. Each accepted start uses up the arming. A read-only busy flag covers the whole transfer.

The register port is plain. Every access completes in the cycle it is presented, and there is no back-pressure. Writes land on the rising clock edge. Reads are combinational while `bus_sel` and `bus_rd` are high.

Top module: `sync_shift_port`

## Requirements
- R1: Address 0 holds word bits 3..0 and address 1 holds word bits 7..4. An idle write stores `bus_wdata` there, and a read returns the stored nibble.
- R2: Address 2 is the control register. Bit 0 is the start bit: writing 1 requests a transfer, writing 0 does nothing, and it always reads as 0. Bit 1 is the busy flag, which is read-only. All other bits read 0.
- R3: A start request is honoured only if a data-register read or write has happened while idle since reset or since the last accepted start. Otherwise it is dropped.
- R4: Busy reads 1 from the cycle after an accepted start until the clock edge that handles the 8th rising shift-clock edge. After that edge it reads 0.
- R5: On the k-th falling shift-clock edge of a transfer (k = 1..8), `sdo` takes word bit 0 as it stands at that moment. It holds its value at every other time. The result is that the loaded word leaves least significant bit first.
- R6: On each rising shift-clock edge, the synchronized `sdi` enters word bit 7 and the word shifts one place right. After 8 bits, the first bit received is in bit 0.
- R7: While busy, a further start request is ignored. Data-register writes are ignored, and data-register accesses do not arm the engine.
- R8: In internal mode, `sclk_out` is 1 at idle and toggles on every `tick_en` cycle while busy. `sclk_oe` is 1 exactly while busy in internal mode.
- R9: In external mode, `sclk_in` and `sdi` each pass two synchronizing flops, and an edge is acted on one cycle after that. Edges that arrive while idle are ignored. `sclk_oe` stays 0.
- R10: After reset, busy and the arming are cleared, `sclk_out` is 1 and `sdo` is 0. The data word is undefined until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | ADDR_W | Register address (0, 1 data; 2 control) |
| bus_wdata | input | NIB_W | Write data |
| bus_rdata | output | NIB_W | Read data, 0 when not reading |
| ext_mode | input | 1 | 1 selects the external shift clock |
| tick_en | input | 1 | Internal shift-clock half-period strobe |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
Some rules are checked by the assertions on every cycle:
- busy can only rise after an armed start write, and it falls only on the 8th rising event;
- `sdo` and the word hold still between their shift events;
- the start bit always reads 0;
- the shift clock idles high, and its output enable is tied to busy in internal mode.

Other behaviour only the bench's scenarios can show:
- a start request without prior arming is dropped;
- a second start request during a transfer is ignored, as is a write during a transfer;
- external edges that arrive before the start are discarded;
- the byte shifted in over a real external clock matches what was sent.

The bench's per-cycle reference model checks the exact latency of the synchronizer path.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CTRL_TRIG_BIT = 0;
  localparam int CTRL_BUSY_BIT = 1;
  localparam logic SCLK_IDLE   = 1'b1;
  localparam logic SDO_RESET   = 1'b0;
endpackage

// File: rtl/ssp_clk_src.sv
module ssp_clk_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic tick_en,
  input  logic run,
  input  logic sclk_in,
  input  logic sdi,
  output logic sclk_int,
  output logic rise_evt,
  output logic fall_evt,
  output logic sdi_s
);
  import ssp_pkg::*;

  logic [SYNC_STAGES:0]   clk_sh;
  logic [SYNC_STAGES-1:0] dat_sh;
  logic ext_rise, ext_fall, int_rise, int_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh <= '1;
      dat_sh <= '0;
    end else begin
      clk_sh <= {clk_sh[SYNC_STAGES-1:0], sclk_in};
      dat_sh <= {dat_sh[SYNC_STAGES-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sclk_int <= SCLK_IDLE;
    else if (!ext_mode && run && tick_en)
      sclk_int <= ~sclk_int;
  end

  assign ext_rise = clk_sh[SYNC_STAGES-1] & ~clk_sh[SYNC_STAGES];
  assign ext_fall = ~clk_sh[SYNC_STAGES-1] & clk_sh[SYNC_STAGES];
  assign int_rise = tick_en & ~sclk_int;
  assign int_fall = tick_en & sclk_int;

  assign rise_evt = run & (ext_mode ? ext_rise : int_rise);
  assign fall_evt = run & (ext_mode ? ext_fall : int_fall);
  assign sdi_s    = dat_sh[SYNC_STAGES-1];
endmodule

// File: rtl/ssp_shift_eng.sv
module ssp_shift_eng #(
  parameter int WORD_W = 8,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 2,
  localparam int NIBS  = WORD_W / NIB_W,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              sdi_s,
  input  logic              data_wr,
  input  logic [ADDR_W-1:0] data_idx,
  input  logic [NIB_W-1:0]  wr_nib,
  output logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              sdo,
  output logic [CNT_W-1:0]  cnt
);
  import ssp_pkg::*;

  logic [WORD_W-1:0] word_d;
  logic              last_bit;

  assign last_bit = (cnt == CNT_W'(WORD_W - 1));

  always_comb begin
    word_d = word;
    if (rise_evt)
      word_d = {sdi_s, word[WORD_W-1:1]};
    else if (data_wr)
      for (int i = 0; i < NIBS; i++)
        if (data_idx == ADDR_W'(i))
          word_d[i*NIB_W +: NIB_W] = wr_nib;
  end

  always_ff @(posedge clk)
    word <= word_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sdo  <= SDO_RESET;
    end else begin
      if (fall_evt)
        sdo <= word[0];
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (rise_evt) begin
        cnt <= cnt + CNT_W'(1);
        if (last_bit)
          busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssp_reg_if.sv
module ssp_reg_if #(
  parameter int WORD_W = 8,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 2,
  localparam int NIBS  = WORD_W / NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  input  logic              busy,
  input  logic [WORD_W-1:0] word,
  output logic [NIB_W-1:0]  bus_rdata,
  output logic              start,
  output logic              data_wr,
  output logic              armed
);
  import ssp_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NIBS);

  logic is_data, is_ctrl, data_acc;

  assign is_data  = bus_addr < CTRL_ADDR;
  assign is_ctrl  = bus_addr == CTRL_ADDR;
  assign data_acc = bus_sel & (bus_wr | bus_rd) & is_data & ~busy;
  assign data_wr  = bus_sel & bus_wr & is_data & ~busy;
  assign start    = bus_sel & bus_wr & is_ctrl & bus_wdata[CTRL_TRIG_BIT] & armed & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (start)
      armed <= 1'b0;
    else if (data_acc)
      armed <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      if (is_ctrl)
        bus_rdata[CTRL_BUSY_BIT] = busy;
      else
        for (int i = 0; i < NIBS; i++)
          if (bus_addr == ADDR_W'(i))
            bus_rdata = word[i*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int WORD_W      = 8,
  parameter int NIB_W       = 4,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              ext_mode,
  input  logic              tick_en,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              busy, armed, start, data_wr;
  logic              rise_evt, fall_evt, sdi_s;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;

  ssp_reg_if #(.WORD_W(WORD_W), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .word(word), .bus_rdata(bus_rdata), .start(start),
    .data_wr(data_wr), .armed(armed)
  );

  ssp_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tick_en(tick_en),
    .run(busy), .sclk_in(sclk_in), .sdi(sdi), .sclk_int(sclk_out),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .sdi_s(sdi_s)
  );

  ssp_shift_eng #(.WORD_W(WORD_W), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .sdi_s(sdi_s), .data_wr(data_wr),
    .data_idx(bus_addr), .wr_nib(bus_wdata), .word(word), .busy(busy),
    .sdo(sdo), .cnt(cnt)
  );

  assign sclk_oe = busy & ~ext_mode;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int WORD_W = 8,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 2,
  localparam int NIBS  = WORD_W / NIB_W,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              trig_bit,
  input logic              rd_trig_bit,
  input logic              ext_mode,
  input logic              sclk_out,
  input logic              sclk_oe,
  input logic              sdo,
  input logic              busy,
  input logic              armed,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic [WORD_W-1:0] word,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NIBS);

  p_trig_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr == CTRL_ADDR) |-> !rd_trig_bit);

  p_start_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  p_busy_from_trigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_sel && bus_wr && bus_addr == CTRL_ADDR && trig_bit));

  p_busy_ends_last_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rise_evt && cnt == CNT_W'(WORD_W - 1)));

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));

  p_sdo_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sdo));

  p_word_holds_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rise_evt) |=> $stable(word));

  p_sclk_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);

  p_oe_tracks_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> (busy && !ext_mode));
endmodule

bind sync_shift_port ssp_checker #(.WORD_W(WORD_W), .NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .trig_bit(bus_wdata[0]), .rd_trig_bit(bus_rdata[0]),
  .ext_mode(ext_mode), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo),
  .busy(busy), .armed(armed), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .word(word), .cnt(cnt)
);

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       ext_mode = 1'b0, tick_en = 1'b0, sclk_in = 1'b1, sdi = 1'b0;
  logic       sclk_out, sclk_oe, sdo;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit tick_on = 1'b0, sdi_auto = 1'b0;
  int tick_div = 0;
  logic [7:0] lfsr = 8'h5B;

  sync_shift_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_mode(ext_mode), .tick_en(tick_en), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit m_busy, m_sdo, m_sclk, m_armed;
  int m_cnt;
  logic [7:0] m_word = '0, m_vmask = '0;
  int qs[$];
  int qd[$];
  bit s2, s3, d2, rise, fall, acc, wrd, st, busy0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_sdo = 0; m_sclk = 1; m_armed = 0;
      qs = '{1, 1, 1};
      qd = '{0, 0};
    end else begin
      s2 = qs[1] != 0; s3 = qs[2] != 0; d2 = qd[1] != 0; busy0 = m_busy;
      if (ext_mode) begin
        rise = busy0 && s2 && !s3;
        fall = busy0 && !s2 && s3;
      end else begin
        rise = busy0 && tick_en && !m_sclk;
        fall = busy0 && tick_en && m_sclk;
      end
      acc = bus_sel && (bus_wr || bus_rd) && bus_addr < 2 && !busy0;
      wrd = bus_sel && bus_wr && bus_addr < 2 && !busy0;
      st  = bus_sel && bus_wr && bus_addr == 2 && bus_wdata[0] && m_armed && !busy0;
      if (!ext_mode && busy0 && tick_en) m_sclk = !m_sclk;
      if (fall) m_sdo = m_word[0];
      if (rise) begin
        m_word  = {d2, m_word[7:1]};
        m_vmask = {1'b1, m_vmask[7:1]};
        m_cnt++;
        if (m_cnt == 8) m_busy = 0;
      end
      if (wrd) begin
        if (bus_addr == 0) begin m_word[3:0] = bus_wdata; m_vmask[3:0] = '1; end
        else begin m_word[7:4] = bus_wdata; m_vmask[7:4] = '1; end
      end
      if (st) begin m_busy = 1; m_cnt = 0; m_armed = 0; end
      else if (acc) m_armed = 1;
      qs.push_front(int'(sclk_in)); void'(qs.pop_back());
      qd.push_front(int'(sdi));     void'(qd.pop_back());
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R5", "sdo", int'(sdo), int'(m_sdo));
      chk("R8", "sclk_out", int'(sclk_out), int'(m_sclk));
      chk(ext_mode ? "R9" : "R8", "sclk_oe", int'(sclk_oe), int'(m_busy && !ext_mode));
      if (bus_sel && bus_rd) begin
        if (bus_addr == 2)
          chk("R4", "ctrl read", int'(bus_rdata), int'(m_busy) << 1);
        else if (bus_addr == 0 && m_vmask[3:0] == 4'hF)
          chk("R1", "low nibble", int'(bus_rdata), int'(m_word[3:0]));
        else if (bus_addr == 1 && m_vmask[7:4] == 4'hF)
          chk("R1", "high nibble", int'(bus_rdata), int'(m_word[7:4]));
      end
    end
  end

  // Stimulus helpers for tick and serial input
  always @(negedge clk) begin
    if (tick_on) begin
      tick_div = (tick_div == 2) ? 0 : tick_div + 1;
      tick_en <= (tick_div == 2);
    end else
      tick_en <= 1'b0;
    if (sdi_auto) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sdi <= lfsr[0];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_bad++;
      $display("FAIL R4 watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [3:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #2;
    chk(tag, "register read", int'(bus_rdata), int'(e));
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] tx;
    idle(4);
    @(negedge clk); rst_n = 1;
    #2;
    chk("R10", "sdo after reset", int'(sdo), 0);
    chk("R10", "sclk_out after reset", int'(sclk_out), 1);
    rd_chk(2, 4'h0, "R10");

    // R3: start without any data access is dropped
    wr(2, 4'h1);
    idle(3);
    rd_chk(2, 4'h0, "R3");

    // R1: nibble mapping, then internal-mode transfer
    wr(0, 4'h5);
    wr(1, 4'hA);
    rd_chk(0, 4'h5, "R1");
    rd_chk(1, 4'hA, "R1");
    wr(2, 4'h0);                 // R2: writing 0 does nothing
    idle(2);
    rd_chk(2, 4'h0, "R2");
    sdi_auto = 1; tick_on = 1;
    wr(2, 4'h1);                 // R2: start bit, reads back 0 with busy set
    rd_chk(2, 4'h2, "R2");
    idle(6);
    wr(2, 4'h1);                 // R7: restart attempt ignored
    wr(0, 4'hF);                 // R7: write while busy ignored
    rd_chk(2, 4'h2, "R7");
    idle(70);
    rd_chk(2, 4'h0, "R4");
    tick_on = 0; sdi_auto = 0;
    // R7: busy-time access did not arm, so this start is dropped
    wr(2, 4'h1);
    idle(2);
    rd_chk(2, 4'h0, "R7");

    // R9 / R6 / R5: external clock mode
    ext_mode = 1;
    idle(2);
    @(negedge clk); sclk_in = 0; idle(4);
    @(negedge clk); sclk_in = 1; idle(4);
    rd_chk(2, 4'h0, "R9");
    tx = 8'hC6; rx = 8'h3C;
    wr(0, tx[3:0]);
    wr(1, tx[7:4]);
    wr(2, 4'h1);
    idle(2);
    rd_chk(2, 4'h2, "R9");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk_in = 0; sdi = rx[i];
      idle(4);
      chk("R5", "sdo bit", int'(sdo), int'(tx[i]));
      @(negedge clk); sclk_in = 1;
      idle(4);
    end
    idle(6);
    rd_chk(2, 4'h0, "R4");
    rd_chk(0, rx[3:0], "R6");
    rd_chk(1, rx[7:4], "R6");
    ext_mode = 0;
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule